// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block arbitrates among a parameterised number of interrupt request lines. Each line carries an 8-bit priority, and a numerically lower value is more urgent. A grouping point splits that byte into two fields. The upper field is the preemption level, which decides whether a request may interrupt a running handler. The lower field is the sub-priority, which only orders requests that share a preemption level. Pending bits hold requests until the core acknowledges entry. A stack of active preemption levels tracks nested handlers and unwinds them in last-in-first-out order.

The core sees a registered take request together with the number of the winning line. It answers with an entry acknowledge that carries the line number it entered, and later with a return acknowledge. A global mask input holds off every take request, but requests that arrive while it is set are still recorded. A sideband write port loads per-line priorities and the grouping point. A write takes effect for arbitration from the cycle after it is made.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `take_req` is 0, `act_level` is 9'h100 (idle, less urgent than any level), `pend_bits` is 0 and `stack_err` is 0.
- R2: Among eligible requests the one with the lowest 8-bit priority value wins, and `take_id` gives its line number.
- R3: `take_req` is 1 only when the winner's preemption field, zero-extended to 9 bits, is strictly below `act_level`. A request whose preemption field equals the active level never nests.
- R4: With grouping point g (0..7), the preemption field is the priority with its low g bits cleared, and those low g bits are the sub-priority. The sub-priority orders pending requests that share a preemption field, and it never causes a take.
- R5: If two requests tie on the full priority value, the lower line number wins.
- R6: A line sampled high sets its pending bit. The bit clears on the edge where `entry_ack` names that line, and the clear wins over a request sampled on the same edge. If the line is still high on the next edge, the bit sets again and the interrupt is taken again once its handler returns.
- R7: While `mask_all` is sampled 1, `take_req` stays 0 and arriving requests still set their pending bits. On the first edge where `mask_all` is sampled 0, the pending winner is offered.
- R8: An entry pushes the preemption field of `prio[entry_id]` onto the active stack, and this becomes `act_level`. A return pops the stack and restores the previous level, or 9'h100 when the stack empties.
- R9: An entry while the stack already holds STACK_DEPTH levels is not pushed and sets `stack_err`, which stays 1 until reset.
- R10: If entry and return are acknowledged on the same edge with a non-empty stack, the top level is replaced by the new one and the depth is unchanged.
- R11: `take_req`, `take_id`, `act_level` and `pend_bits` are registered. They reflect requests, acknowledges and the mask sampled on an edge right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Request lines, sampled each edge |
| mask_all | input | 1 | Global mask that suppresses take requests |
| cfg_prio_we | input | 1 | Priority write strobe |
| cfg_prio_idx | input | IRQ_W | Line whose priority is written |
| cfg_prio_val | input | 8 | New priority value |
| cfg_grp_we | input | 1 | Grouping point write strobe |
| cfg_grp_val | input | 3 | New grouping point (number of sub-priority bits) |
| entry_ack | input | 1 | Core has entered a handler |
| entry_id | input | IRQ_W | Line number of the handler entered |
| ret_ack | input | 1 | Core has returned from the current handler |
| take_req | output | 1 | Request to take an interrupt |
| take_id | output | IRQ_W | Winning line number |
| act_level | output | 9 | Current active preemption level, 9'h100 when idle |
| pend_bits | output | NUM_IRQ | Pending bits |
| stack_err | output | 1 | Sticky overflow of the active stack |

## Verification
Two pairs of events can land on the same edge. In the first, an entry acknowledge clears a pending bit while the same request line is still sampled high. The bench holds a level request through its entry and checks that the pending bit reads 0 after the acknowledge edge and 1 one edge later. It also checks that the interrupt is offered again right after the return. In the second, entry and return are acknowledged together. The bench drives both strobes in one cycle over a one-deep stack, checks that the new level replaces the old one, and then checks that a single return brings the block back to idle.

// File: rtl/irq_pc_pkg.sv
package irq_pc_pkg;
   localparam int PRIO_W = 8;
   localparam int LVL_W  = PRIO_W + 1;
   localparam logic [LVL_W-1:0] LVL_IDLE = {1'b1, {PRIO_W{1'b0}}};

   typedef logic [PRIO_W-1:0] prio_t;

   // preemption field: priority with the low 'grp' sub-priority bits cleared
   function automatic prio_t pre_of(input prio_t p, input logic [2:0] grp);
      prio_t m;
      m = prio_t'({PRIO_W{1'b1}} << grp);
      return p & m;
   endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int NUM_IRQ = 8,
   localparam int IRQ_W = $clog2(NUM_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] req,
   input  logic               clr_en,
   input  logic [IRQ_W-1:0]   clr_id,
   output logic [NUM_IRQ-1:0] pend_q,
   output logic [NUM_IRQ-1:0] pend_nxt
);
   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
      logic clr_g;
      assign clr_g       = clr_en && (clr_id == IRQ_W'(g));
      assign pend_nxt[g] = clr_g ? 1'b0 : (pend_q[g] | req[g]);
      always_ff @(posedge clk) begin
         if (!rst_n) pend_q[g] <= 1'b0;
         else        pend_q[g] <= pend_nxt[g];
      end
   end

   // R6: acknowledged line reads clear after the entry edge
   a_r6_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !pend_q[$past(clr_id)]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pc_pkg::*;
#(
   parameter int NUM_IRQ = 8,
   localparam int IRQ_W = $clog2(NUM_IRQ)
) (
   input  logic [NUM_IRQ-1:0]             elig,
   input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
   output logic                           win_vld,
   output logic [IRQ_W-1:0]               win_id,
   output prio_t                          win_prio
);
   // scan from the top index down; '<=' lets the lower index take ties
   always_comb begin
      win_vld  = 1'b0;
      win_id   = '0;
      win_prio = '1;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (elig[i] && (!win_vld || prio[i] <= win_prio)) begin
            win_vld  = 1'b1;
            win_id   = IRQ_W'(i);
            win_prio = prio[i];
         end
      end
   end

   // R2: a valid winner is always one of the eligible lines
   a_r2_winner_eligible: assert final (!win_vld || elig[win_id]);
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack
   import irq_pc_pkg::*;
#(
   parameter int STACK_DEPTH = 4,
   localparam int DW = $clog2(STACK_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  prio_t            push_val,
   output logic [LVL_W-1:0] level_q,
   output logic [LVL_W-1:0] level_nxt,
   output logic             err_q
);
   prio_t [STACK_DEPTH-1:0] mem_q, mem_n;
   logic  [DW-1:0]          dep_q, dep_n;
   logic                    err_n;
   logic                    full;

   assign full = (dep_q == DW'(STACK_DEPTH));

   always_comb begin
      mem_n = mem_q;
      dep_n = dep_q;
      err_n = err_q;
      if (push && pop && dep_q != '0) begin
         for (int k = 0; k < STACK_DEPTH; k++)
            if (k == int'(dep_q) - 1) mem_n[k] = push_val;
      end else if (push && pop) begin
         mem_n[0] = push_val;
         dep_n    = DW'(1);
      end else if (push) begin
         if (full) err_n = 1'b1;
         else begin
            for (int k = 0; k < STACK_DEPTH; k++)
               if (k == int'(dep_q)) mem_n[k] = push_val;
            dep_n = dep_q + DW'(1);
         end
      end else if (pop && dep_q != '0) begin
         dep_n = dep_q - DW'(1);
      end
   end

   always_comb begin
      level_nxt = LVL_IDLE;
      for (int k = 0; k < STACK_DEPTH; k++)
         if (k == int'(dep_n) - 1) level_nxt = {1'b0, mem_n[k]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q   <= '0;
         dep_q   <= '0;
         err_q   <= 1'b0;
         level_q <= LVL_IDLE;
      end else begin
         mem_q   <= mem_n;
         dep_q   <= dep_n;
         err_q   <= err_n;
         level_q <= level_nxt;
      end
   end

   // R8: a lone return drops exactly one level
   a_r8_pop_unwinds: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && dep_q != '0) |=> dep_q == $past(dep_q) - DW'(1));
   // R9: push into a full stack flags and leaves the level alone
   a_r9_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && full) |=> (err_q && level_q == $past(level_q)));
   // R10: combined entry and return keeps the depth
   a_r10_swap_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && dep_q != '0) |=> dep_q == $past(dep_q));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pc_pkg::*;
#(
   parameter int NUM_IRQ     = 8,
   parameter int STACK_DEPTH = 4,
   localparam int IRQ_W = $clog2(NUM_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               mask_all,
   input  logic               cfg_prio_we,
   input  logic [IRQ_W-1:0]   cfg_prio_idx,
   input  logic [7:0]         cfg_prio_val,
   input  logic               cfg_grp_we,
   input  logic [2:0]         cfg_grp_val,
   input  logic               entry_ack,
   input  logic [IRQ_W-1:0]   entry_id,
   input  logic               ret_ack,
   output logic               take_req,
   output logic [IRQ_W-1:0]   take_id,
   output logic [8:0]         act_level,
   output logic [NUM_IRQ-1:0] pend_bits,
   output logic               stack_err
);
   if (NUM_IRQ < 2) begin : g_bad_n
      $error("NUM_IRQ must be at least 2");
   end
   if (STACK_DEPTH < 1 || STACK_DEPTH > 256) begin : g_bad_d
      $error("STACK_DEPTH must be in 1..256");
   end
   if (PRIO_W != 8) begin : g_bad_w
      $error("priority byte must be 8 bits");
   end

   prio_t [NUM_IRQ-1:0] prio_q;
   logic  [2:0]         grp_q;
   logic  [NUM_IRQ-1:0] pend_q, pend_nxt;
   logic  [LVL_W-1:0]   lvl_q, lvl_nxt;
   logic                win_vld;
   logic  [IRQ_W-1:0]   win_id;
   prio_t               win_prio;
   logic                take_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q <= '0;
         grp_q  <= '0;
      end else begin
         if (cfg_prio_we) prio_q[cfg_prio_idx] <= cfg_prio_val;
         if (cfg_grp_we)  grp_q <= cfg_grp_val;
      end
   end

   irq_pend_bank #(.NUM_IRQ(NUM_IRQ)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (irq_req),
      .clr_en   (entry_ack),
      .clr_id   (entry_id),
      .pend_q   (pend_q),
      .pend_nxt (pend_nxt)
   );

   irq_active_stack #(.STACK_DEPTH(STACK_DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (entry_ack),
      .pop       (ret_ack),
      .push_val  (pre_of(prio_q[entry_id], grp_q)),
      .level_q   (lvl_q),
      .level_nxt (lvl_nxt),
      .err_q     (stack_err)
   );

   // arbitrate over the state that the coming edge will hold
   irq_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
      .elig     (pend_nxt),
      .prio     (prio_q),
      .win_vld  (win_vld),
      .win_id   (win_id),
      .win_prio (win_prio)
   );

   assign take_nxt = win_vld && !mask_all &&
                     ({1'b0, pre_of(win_prio, grp_q)} < lvl_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_req <= 1'b0;
         take_id  <= '0;
      end else begin
         take_req <= take_nxt;
         take_id  <= win_id;
      end
   end

   assign act_level = lvl_q;
   assign pend_bits = pend_q;

   // R2: an offered line is pending in the bank
   a_r2_take_pending: assert property (@(posedge clk) disable iff (!rst_n)
      take_req |-> pend_q[take_id]);
   // R7: mask sampled set means no offer after that edge
   a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      mask_all |=> !take_req);
   // R3: an offer is strictly more urgent than the active level
   a_r3_strict_nest: assert property (@(posedge clk) disable iff (!rst_n)
      (take_req && !$past(cfg_prio_we) && !$past(cfg_grp_we)) |->
         ({1'b0, pre_of(prio_q[take_id], grp_q)} < act_level));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_req = '0;
   logic         mask_all = 1'b0;
   logic         cfg_prio_we = 1'b0;
   logic [W-1:0] cfg_prio_idx = '0;
   logic [7:0]   cfg_prio_val = '0;
   logic         cfg_grp_we = 1'b0;
   logic [2:0]   cfg_grp_val = '0;
   logic         entry_ack = 1'b0;
   logic [W-1:0] entry_id = '0;
   logic         ret_ack = 1'b0;
   logic         take_req;
   logic [W-1:0] take_id;
   logic [8:0]   act_level;
   logic [N-1:0] pend_bits;
   logic         stack_err;

   int n_chk = 0;
   int n_bad = 0;

   irq_prio_ctrl #(.NUM_IRQ(N), .STACK_DEPTH(4)) u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_all(mask_all),
      .cfg_prio_we(cfg_prio_we), .cfg_prio_idx(cfg_prio_idx),
      .cfg_prio_val(cfg_prio_val), .cfg_grp_we(cfg_grp_we),
      .cfg_grp_val(cfg_grp_val), .entry_ack(entry_ack), .entry_id(entry_id),
      .ret_ack(ret_ack), .take_req(take_req), .take_id(take_id),
      .act_level(act_level), .pend_bits(pend_bits), .stack_err(stack_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_prio(input int id, input int val);
      cfg_prio_we = 1'b1; cfg_prio_idx = W'(id); cfg_prio_val = 8'(val);
      cyc();
      cfg_prio_we = 1'b0;
   endtask

   task automatic set_grp(input int g);
      cfg_grp_we = 1'b1; cfg_grp_val = 3'(g);
      cyc();
      cfg_grp_we = 1'b0;
   endtask

   task automatic pulse(input int id);
      irq_req[id] = 1'b1;
      cyc();
      irq_req[id] = 1'b0;
   endtask

   task automatic enter(input int id);
      entry_ack = 1'b1; entry_id = W'(id);
      cyc();
      entry_ack = 1'b0;
   endtask

   task automatic leave();
      ret_ack = 1'b1;
      cyc();
      ret_ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 take_req", int'(take_req), 0);
      chk("R1 act_level", int'(act_level), 'h100);
      chk("R1 pend_bits", int'(pend_bits), 0);
      chk("R1 stack_err", int'(stack_err), 0);
   endtask

   task automatic t_single_and_nest();
      set_prio(3, 'h40); set_prio(5, 'h20); set_prio(1, 'h20);
      pulse(3);
      chk("R11 take_req after one edge", int'(take_req), 1);
      chk("R2 take_id", int'(take_id), 3);
      enter(3);
      chk("R8 level after entry", int'(act_level), 'h40);
      chk("R6 pending cleared", int'(pend_bits[3]), 0);
      chk("R3 no offer at own level", int'(take_req), 0);
      pulse(5);
      chk("R3 more urgent nests", int'(take_req), 1);
      chk("R3 nest id", int'(take_id), 5);
      enter(5);
      chk("R8 nested level", int'(act_level), 'h20);
      pulse(1);
      chk("R3 equal level does not nest", int'(take_req), 0);
      chk("R3 equal level stays pending", int'(pend_bits[1]), 1);
      leave();
      chk("R8 LIFO restores outer level", int'(act_level), 'h40);
      chk("R3 waiting one offered after return", int'(take_req), 1);
      chk("R3 waiting id", int'(take_id), 1);
      enter(1); leave();
      chk("R8 back to outer", int'(act_level), 'h40);
      leave();
      chk("R8 idle after last return", int'(act_level), 'h100);
   endtask

   task automatic t_subprio();
      set_grp(5);
      set_prio(0, 'h48); set_prio(6, 'h41); set_prio(2, 'h45);
      pulse(0); enter(0);
      chk("R4 stored level is masked", int'(act_level), 'h40);
      pulse(6);
      chk("R4 sub-priority does not preempt", int'(take_req), 0);
      pulse(2);
      chk("R4 still no preempt", int'(take_req), 0);
      leave();
      chk("R4 offer after return", int'(take_req), 1);
      chk("R4 sub-priority orders", int'(take_id), 6);
      enter(6); leave();
      chk("R4 second in order", int'(take_id), 2);
      enter(2); leave();
      chk("R4 idle", int'(act_level), 'h100);
      set_grp(0);
   endtask

   task automatic t_tie();
      set_prio(4, 'h10); set_prio(7, 'h10);
      irq_req[4] = 1'b1; irq_req[7] = 1'b1;
      cyc();
      irq_req[4] = 1'b0; irq_req[7] = 1'b0;
      chk("R5 tie lower number wins", int'(take_id), 4);
      enter(4);
      chk("R5 tied peer does not nest", int'(take_req), 0);
      leave();
      chk("R5 tied peer next", int'(take_id), 7);
      chk("R5 tied peer offered", int'(take_req), 1);
      enter(7); leave();
   endtask

   task automatic t_mask();
      mask_all = 1'b1;
      pulse(3);
      chk("R7 masked no offer", int'(take_req), 0);
      chk("R7 masked request latched", int'(pend_bits[3]), 1);
      cyc();
      chk("R7 still held", int'(take_req), 0);
      mask_all = 1'b0;
      cyc();
      chk("R7 offered on unmask", int'(take_req), 1);
      chk("R7 unmask id", int'(take_id), 3);
      enter(3); leave();
   endtask

   task automatic t_level_reenter();
      set_prio(2, 'h70);
      irq_req[2] = 1'b1;
      cyc();
      chk("R6 level request offered", int'(take_id), 2);
      enter(2);
      chk("R6 clear wins on entry edge", int'(pend_bits[2]), 0);
      cyc();
      chk("R6 held line re-pends", int'(pend_bits[2]), 1);
      chk("R6 no self nest", int'(take_req), 0);
      leave();
      chk("R6 re-entered after return", int'(take_req), 1);
      chk("R6 re-enter id", int'(take_id), 2);
      irq_req[2] = 1'b0;
      enter(2); leave();
      chk("R6 idle", int'(act_level), 'h100);
   endtask

   task automatic t_swap();
      pulse(3); enter(3);
      pulse(5);
      entry_ack = 1'b1; entry_id = W'(5); ret_ack = 1'b1;
      cyc();
      entry_ack = 1'b0; ret_ack = 1'b0;
      chk("R10 top replaced", int'(act_level), 'h20);
      leave();
      chk("R10 depth unchanged, one return to idle", int'(act_level), 'h100);
   endtask

   task automatic t_overflow();
      set_prio(0, 'h80); set_prio(6, 'h60); set_prio(2, 'h40);
      set_prio(4, 'h20); set_prio(7, 'h10);
      enter(0); enter(6); enter(2); enter(4);
      chk("R9 full stack level", int'(act_level), 'h20);
      chk("R9 no error yet", int'(stack_err), 0);
      enter(7);
      chk("R9 overflow flags", int'(stack_err), 1);
      chk("R9 overflow not pushed", int'(act_level), 'h20);
      leave();
      chk("R9 return after overflow", int'(act_level), 'h40);
      leave(); leave(); leave();
      chk("R9 idle", int'(act_level), 'h100);
      chk("R9 flag sticky", int'(stack_err), 1);
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_single_and_nest();
      t_subprio();
      t_tie();
      t_mask();
      t_level_reenter();
      t_swap();
      t_overflow();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule